// File: doc/BRIEF.md
# Byte-Serial Control Slave with Status Relay

This block is the slave end of a clocked serial control port shared by several devices on one bus. A host selects the block by raising an enable line, picks a transaction type on two mode lines and then toggles a serial clock. Data moves in 8-bit units with the least significant bit of each unit first. Two-unit words go upper unit first, and the enable stays high between the units. All serial inputs are brought into the block's own clock domain through a synchronizer and handled by edge detection.

The host can write an 8-bit extended-settings value or a 16-bit settings word. Each goes into its own holding buffer. A buffer shows a pending flag until a downstream forwarding engine takes it with a one-cycle pulse. The contents are never interpreted. The host can also read a 16-bit status word. This word is a copy of the most recent status captured from downstream, except that two bit positions in the upper unit are replaced by local ready-to-receive flags: 1 means the matching buffer is empty. A read may stop after the first unit, which carries the ready flags.

Top module: `byte_ser_ctl_slave`

## Requirements
- R1: The mode lines {ser_mode[1], ser_mode[0]} are sampled when the enable rises: 00 is an extended-settings write of one unit, 10 is a settings write of two units, 11 is a status read and 01 (allocation) is ignored. In mode 01 no buffer changes and ser_dout_en stays 0.
- R2: While ser_en is low, clock and data activity change no buffer, and ser_dout_en stays 0.
- R3: Wire order is bit 8 through bit 15, then bit 0 through bit 7, of a 16-bit word. During a status read, the first bit (word bit 8) is on ser_dout before the first rising serial clock. The output changes only after a falling serial clock edge. Input data is sampled on the rising edge.
- R4: A settings write of exactly 16 bits into an empty buffer stores the word and raises set_pending. Status bit 11 then reads 0 until a set_taken pulse clears set_pending.
- R5: An extended-settings write of exactly 8 bits into an empty buffer stores the byte (wire bits in order 0..7) and raises xset_pending. Status bit 10 then reads 0 until a xset_taken pulse clears it.
- R6: A write whose buffer is still pending is ignored, and the held contents are kept.
- R7: A write whose bit count differs from its mode's length (8 for extended settings, 16 for settings) is discarded when the enable falls.
- R8: Every status bit other than 11 and 10 equals the last dn_status value captured with dn_status_vld. Bits 11 and 10 are the inverted settings and extended-settings pending flags, taken when the enable rises.
- R9: A status read stopped after 8 bits returns the upper byte (bits 15..8). It leaves no effect on the next transaction.
- R10: After reset, both buffers are empty, ser_dout_en is 0 and the captured status is 0, so a status read returns 16'h0C00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_en | input | 1 | Serial select; the port responds only while high |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_mode | input | 2 | Transaction type lines |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial status data to the host |
| ser_dout_en | output | 1 | Drive enable for ser_dout |
| dn_status | input | 16 | Status word from the downstream device |
| dn_status_vld | input | 1 | Capture strobe for dn_status |
| set_data | output | 16 | Held settings word |
| set_pending | output | 1 | Settings buffer full |
| set_taken | input | 1 | Downstream has consumed the settings word |
| xset_data | output | 8 | Held extended-settings byte |
| xset_pending | output | 1 | Extended-settings buffer full |
| xset_taken | input | 1 | Downstream has consumed the extended-settings byte |

## Verification
Directed runs cover each mode in turn:
- full and truncated status reads, which show the wire order and the ready-bit overlay;
- writes into full buffers, which separate "ignored" from "overwritten";
- wrong-length writes, which show whether the bit count gates the commit;
- allocation-mode and deselected traffic, which must leave everything unchanged.

A seeded random mix then interleaves reads, writes of several lengths, downstream status updates and consume pulses. This exposes any stale or mis-ordered ready bit and any commit that slips past a pending buffer.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
   typedef enum logic [1:0] {
      M_XSET  = 2'b00,
      M_ALLOC = 2'b01,
      M_SET   = 2'b10,
      M_STAT  = 2'b11
   } ser_mode_e;
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] ff [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) ff[i] <= '0;
            end else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bsc_shifter.sv
module bsc_shifter
   import bsc_pkg::*;
#(
   parameter int UNIT_W = 8,
   localparam int WORD_W = 2 * UNIT_W,
   localparam int IW     = $clog2(WORD_W),
   localparam int CW     = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              sck,
   input  logic              din,
   input  logic [1:0]        mode,
   input  logic [WORD_W-1:0] tx_word,
   output logic              active,
   output ser_mode_e         mode_q,
   output logic [WORD_W-1:0] rx_word,
   output logic [CW-1:0]     rx_cnt,
   output logic              done,
   output logic              dout
);
   logic              sel_d, sck_d;
   logic [CW-1:0]     tx_cnt;
   logic [WORD_W-1:0] tx_q;
   logic              sel_rise, sck_rise, sck_fall;

   // wire position k -> word bit: upper unit first, LSB first in each unit
   function automatic logic [IW-1:0] map_pos(input logic [CW-1:0] k);
      if (k < CW'(UNIT_W)) return IW'(k + CW'(UNIT_W));
      else                 return IW'(k - CW'(UNIT_W));
   endfunction

   assign sel_rise = sel & ~sel_d;
   assign sck_rise = sck & ~sck_d;
   assign sck_fall = ~sck & sck_d;
   assign done     = active & ~sel;
   assign dout     = tx_q[map_pos(tx_cnt)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_d   <= 1'b0;
         sck_d   <= 1'b0;
         active  <= 1'b0;
         mode_q  <= M_XSET;
         rx_word <= '0;
         rx_cnt  <= '0;
         tx_cnt  <= '0;
         tx_q    <= '0;
      end else begin
         sel_d <= sel;
         sck_d <= sck;
         if (sel_rise) begin
            active  <= 1'b1;
            mode_q  <= ser_mode_e'(mode);
            rx_word <= '0;
            rx_cnt  <= '0;
            tx_cnt  <= '0;
            tx_q    <= tx_word;
         end else if (active) begin
            if (!sel) begin
               active <= 1'b0;
            end else begin
               if (sck_rise && rx_cnt < CW'(WORD_W)) begin
                  rx_word[map_pos(rx_cnt)] <= din;
                  rx_cnt <= rx_cnt + 1'b1;
               end
               if (sck_fall && tx_cnt < CW'(WORD_W - 1))
                  tx_cnt <= tx_cnt + 1'b1;
            end
         end
      end
   end

   p_dout_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && sel && !sck_fall) |=> $stable(dout));

   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt <= CW'(WORD_W)));
endmodule

// File: rtl/bsc_hold.sv
module bsc_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         commit,
   input  logic [W-1:0] wdata,
   input  logic         taken,
   output logic [W-1:0] data,
   output logic         pending
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data    <= '0;
         pending <= 1'b0;
      end else begin
         if (taken) pending <= 1'b0;
         if (commit && !pending) begin
            data    <= wdata;
            pending <= 1'b1;
         end
      end
   end

   p_full_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !taken) |=> ($stable(data) && pending));

   p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !pending) |=> (pending && data == $past(wdata)));
endmodule

// File: rtl/byte_ser_ctl_slave.sv
module byte_ser_ctl_slave
   import bsc_pkg::*;
#(
   parameter int UNIT_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RDY_SET_POS = 11,
   parameter int RDY_EXT_POS = 10,
   localparam int WORD_W = 2 * UNIT_W,
   localparam int CW     = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_en,
   input  logic              ser_clk,
   input  logic [1:0]        ser_mode,
   input  logic              ser_din,
   output logic              ser_dout,
   output logic              ser_dout_en,
   input  logic [WORD_W-1:0] dn_status,
   input  logic              dn_status_vld,
   output logic [WORD_W-1:0] set_data,
   output logic              set_pending,
   input  logic              set_taken,
   output logic [UNIT_W-1:0] xset_data,
   output logic              xset_pending,
   input  logic              xset_taken
);
   generate
      if (UNIT_W < 2) begin : g_bad_unit
         $error("UNIT_W must be at least 2");
      end
      if (RDY_SET_POS < UNIT_W || RDY_SET_POS >= WORD_W ||
          RDY_EXT_POS < UNIT_W || RDY_EXT_POS >= WORD_W ||
          RDY_SET_POS == RDY_EXT_POS) begin : g_bad_pos
         $error("ready bits must be distinct and lie in the upper unit");
      end
   endgenerate

   logic              en_s, sck_s, din_s;
   logic [1:0]        mode_s;
   logic [WORD_W-1:0] stat_q, tx_word, rx_word;
   logic              active, done, dout;
   ser_mode_e         mode_q;
   logic [CW-1:0]     rx_cnt;
   logic              commit_set, commit_ext;

   bsc_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_en, ser_clk, ser_mode, ser_din}),
      .q    ({en_s, sck_s, mode_s, din_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             stat_q <= '0;
      else if (dn_status_vld) stat_q <= dn_status;
   end

   always_comb begin
      tx_word              = stat_q;
      tx_word[RDY_SET_POS] = ~set_pending;
      tx_word[RDY_EXT_POS] = ~xset_pending;
   end

   bsc_shifter #(.UNIT_W(UNIT_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (en_s),
      .sck    (sck_s),
      .din    (din_s),
      .mode   (mode_s),
      .tx_word(tx_word),
      .active (active),
      .mode_q (mode_q),
      .rx_word(rx_word),
      .rx_cnt (rx_cnt),
      .done   (done),
      .dout   (dout)
   );

   assign commit_set = done && mode_q == M_SET  && rx_cnt == CW'(WORD_W);
   assign commit_ext = done && mode_q == M_XSET && rx_cnt == CW'(UNIT_W);

   bsc_hold #(.W(WORD_W)) u_set_buf (
      .clk(clk), .rst_n(rst_n), .commit(commit_set), .wdata(rx_word),
      .taken(set_taken), .data(set_data), .pending(set_pending)
   );

   bsc_hold #(.W(UNIT_W)) u_xset_buf (
      .clk(clk), .rst_n(rst_n), .commit(commit_ext),
      .wdata(rx_word[WORD_W-1:UNIT_W]),
      .taken(xset_taken), .data(xset_data), .pending(xset_pending)
   );

   assign ser_dout_en = active && en_s && mode_q == M_STAT;
   assign ser_dout    = ser_dout_en ? dout : 1'b0;

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |-> !ser_dout_en);

   p_no_alloc_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode_q == M_ALLOC) |=> ($stable(set_data) && $stable(xset_data)));
endmodule

// File: tb/tb_byte_ser_ctl_slave.sv
module tb_byte_ser_ctl_slave;
   localparam int HALF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
   logic [1:0]  ser_mode = 2'b00;
   logic        ser_dout, ser_dout_en;
   logic [15:0] dn_status = '0;
   logic        dn_status_vld = 1'b0;
   logic [15:0] set_data;
   logic        set_pending, set_taken = 1'b0;
   logic [7:0]  xset_data;
   logic        xset_pending, xset_taken = 1'b0;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   logic [15:0] m_dn = '0, m_set = '0;
   logic [7:0]  m_ext = '0;
   bit          m_set_p = 0, m_ext_p = 0;

   always #4 clk = ~clk;

   byte_ser_ctl_slave dut (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
      .ser_mode(ser_mode), .ser_din(ser_din), .ser_dout(ser_dout),
      .ser_dout_en(ser_dout_en), .dn_status(dn_status),
      .dn_status_vld(dn_status_vld), .set_data(set_data),
      .set_pending(set_pending), .set_taken(set_taken),
      .xset_data(xset_data), .xset_pending(xset_pending),
      .xset_taken(xset_taken)
   );

   function automatic logic [15:0] exp_status();
      logic [15:0] s = m_dn;
      s[11] = !m_set_p;
      s[10] = !m_ext_p;
      return s;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [1:0] m, input int nbits, input logic [15:0] w,
                       input bit use_en, output logic [15:0] r, output int bad_en);
      r = '0;
      bad_en = 0;
      ser_mode = m;
      ser_din = 1'b0;
      repeat (HALF) @(negedge clk);
      ser_en = use_en;
      repeat (HALF) @(negedge clk);
      for (int k = 0; k < nbits; k++) begin
         int b = (k < 8) ? k + 8 : k - 8;
         ser_din = w[b];
         repeat (HALF) @(negedge clk);
         r[b] = ser_dout;
         if (ser_dout_en !== (use_en && m == 2'b11)) bad_en++;
         ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      ser_en = 1'b0;
      repeat (3 * HALF) @(negedge clk);
      if (use_en && m == 2'b10 && nbits == 16 && !m_set_p) begin
         m_set = w; m_set_p = 1;
      end
      if (use_en && m == 2'b00 && nbits == 8 && !m_ext_p) begin
         m_ext = w[15:8]; m_ext_p = 1;
      end
   endtask

   task automatic read_status(input int nbits, input string req);
      logic [15:0] r, e;
      int bad;
      e = exp_status();
      xfer(2'b11, nbits, 16'h0, 1'b1, r, bad);
      check(bad == 0, "R3 dout_en during read", bad, 0);
      if (nbits == 8) check(r[15:8] == e[15:8], req, r[15:8], e[15:8]);
      else            check(r == e, req, r, e);
   endtask

   task automatic write_op(input logic [1:0] m, input int nbits,
                           input logic [15:0] w, input bit use_en, input string req);
      logic [15:0] r;
      int bad;
      xfer(m, nbits, w, use_en, r, bad);
      check(bad == 0, "R2 dout_en stays low on writes", bad, 0);
      check_bufs(req);
   endtask

   task automatic check_bufs(input string req);
      check(set_pending == m_set_p, {req, " set_pending"}, set_pending, m_set_p);
      check(set_data == m_set, {req, " set_data"}, set_data, m_set);
      check(xset_pending == m_ext_p, {req, " xset_pending"}, xset_pending, m_ext_p);
      check(xset_data == m_ext, {req, " xset_data"}, xset_data, m_ext);
   endtask

   task automatic take(input bit which_set);
      @(negedge clk);
      if (which_set) set_taken = 1'b1; else xset_taken = 1'b1;
      @(negedge clk);
      set_taken = 1'b0; xset_taken = 1'b0;
      if (which_set) m_set_p = 0; else m_ext_p = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic dn_update(input logic [15:0] v);
      @(negedge clk);
      dn_status = v; dn_status_vld = 1'b1;
      @(negedge clk);
      dn_status_vld = 1'b0;
      dn_status = ~v;
      m_dn = v;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R10: reset state
      check(!set_pending && !xset_pending, "R10 buffers empty",
            {set_pending, xset_pending}, 0);
      check(!ser_dout_en, "R10 dout_en low", ser_dout_en, 0);
      read_status(16, "R10 status after reset");

      // R8: relay with overlay
      dn_update(16'hA5F3);
      read_status(16, "R8 status relay");
      dn_update(16'h0000);
      read_status(16, "R8 status relay zero");
      dn_update(16'hFFFF);

      // R4 settings write, R6 ignore while full
      write_op(2'b10, 16, 16'h1234, 1'b1, "R4 settings write");
      read_status(16, "R4 ready bit low");
      write_op(2'b10, 16, 16'hFFFF, 1'b1, "R6 settings while full");
      take(1);
      check_bufs("R4 after taken");
      read_status(16, "R4 ready bit back");

      // R5 extended settings, R6 ignore, R9 truncated read
      write_op(2'b00, 8, 16'h5A00, 1'b1, "R5 ext write");
      write_op(2'b00, 8, 16'h3300, 1'b1, "R6 ext while full");
      read_status(8, "R9 truncated read");
      read_status(16, "R9 full read after truncated");
      take(0);
      check_bufs("R5 after taken");

      // R7 wrong lengths
      write_op(2'b10, 8, 16'hBEEF, 1'b1, "R7 short settings");
      write_op(2'b10, 12, 16'hBEEF, 1'b1, "R7 12-bit settings");
      write_op(2'b00, 16, 16'hC3C3, 1'b1, "R7 long ext");

      // R1 allocation ignored, R2 deselected ignored
      write_op(2'b01, 16, 16'h7777, 1'b1, "R1 allocation ignored");
      write_op(2'b10, 16, 16'h4321, 1'b0, "R2 deselected settings");
      write_op(2'b00, 8, 16'h9900, 1'b0, "R2 deselected ext");

      // random mix
      for (int it = 0; it < 120; it++) begin
         int op = $urandom_range(0, 9);
         logic [15:0] w = 16'($urandom);
         int lsel = $urandom_range(0, 4);
         bit en = ($urandom_range(0, 9) != 0);
         case (op)
            0, 1:    read_status(16, "R8 random status");
            2:       read_status(8, "R9 random short status");
            3, 4:    write_op(2'b10, (lsel == 0) ? 8 : 16, w, en, "R4 random settings");
            5:       write_op(2'b00, (lsel == 0) ? 16 : 8, w, en, "R5 random ext");
            6:       write_op(2'b01, 16, w, en, "R1 random alloc");
            7:       begin take(1); check_bufs("R4 random take"); end
            8:       begin take(0); check_bufs("R5 random take"); end
            default: dn_update(w);
         endcase
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule